// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a single-master controller for a two-wire serial bus. It performs one complete register operation on an addressed target per command. A host places a 7-bit target address, an 8-bit register index, an 8-bit write value and a direction select on its inputs and raises a one-cycle strobe. The controller captures all of these on the accepting edge and runs the whole bus transfer by itself. When the transfer ends it raises a single-cycle completion pulse. On a completed read the received byte appears on the result output.

A write sends the address with the direction bit cleared, then the register index, then the value, and closes with a STOP. A read always starts the same way, with the address and write bit followed by the register index, so that the target's pointer is set first. It then issues a repeated START with no STOP before it, sends the address with the direction bit set, and clocks in one byte. The controller refuses that byte with a NACK and closes with a STOP. If the target refuses any byte the master sends, the transfer is cut short with a STOP and the completion pulse carries an error flag.

Both bus lines are open drain. The block drives an output-enable for each line, where 1 pulls the line low, and reads the SDA line back through a two-stage synchronizer. Every bit on the bus occupies four quarter periods, and a quarter period lasts `QTR_CLKS` system clocks. SCL is low in quarters 0 and 1 and high in quarters 2 and 3. SDA moves at the start of quarter 1 and is sampled at the start of quarter 3.

Top module: `i2creg_master`

## Requirements
- R1: Outside a transfer (busy low) both output-enables are 0, so SCL and SDA both read high; this is also the state after reset, with busy, done, the error flag and the result byte all 0.
- R2: Each transfer opens with a START, meaning SDA falls while SCL is high. A write or an aborted transfer contains exactly one START and one STOP, where a STOP means SDA rises while SCL is high.
- R3: The first byte after each START is the 7-bit target address followed by the direction bit, which is 0 for write and 1 for read (address 7'h68 gives 8'hD0 and 8'hD1).
- R4: Every byte is sent MSB first and takes nine SCL pulses. In the ninth pulse SDA low means accepted and SDA high means refused. Each pulse lasts 4*QTR_CLKS clocks.
- R5: A write stores the value in the target register named by the index. A successful write lasts 29 bit cells: START, three bytes and STOP.
- R6: A read sends the index and then a repeated START with no STOP between them, and returns the addressed register on the result output. It has two STARTs and one STOP and lasts 39 bit cells.
- R7: In the ninth pulse of the received byte the controller leaves SDA released, which is a NACK.
- R8: When the target refuses a byte the master sent, the controller ends with a STOP right after that byte's ninth pulse. It then raises the error flag in the same cycle as done and clears busy. A refused address takes 11 cells and a refused index takes 20 cells.
- R9: The error flag keeps its value after done until the next accepted command, and it is 0 after a transfer that succeeds.
- R10: SCL and SDA output-enables never change in the same clock cycle; data changes only with SCL low and START/STOP only with SCL high.
- R11: A strobe while busy is ignored. All command inputs are captured when the strobe is accepted, so changing them later has no effect on the running transfer.
- R12: Busy rises in the cycle after the accepting edge and stays high until done. Done lasts exactly one cycle and coincides with busy falling.
- R13: The result output changes only at the end of a successful read. Writes and aborted transfers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_read | input | 1 | 1 selects register read, 0 register write |
| cmd_dev | input | 7 | Target device address |
| cmd_reg | input | 8 | Register index inside the target |
| cmd_wdata | input | 8 | Value for a write |
| rsp_rdata | output | 8 | Byte returned by the last successful read |
| rsp_busy | output | 1 | High while a transfer runs |
| rsp_done | output | 1 | One-cycle pulse at the end of a transfer |
| rsp_nack | output | 1 | Target refused a byte in the last transfer |
| scl_oe | output | 1 | 1 pulls the SCL line low |
| sda_oe | output | 1 | 1 pulls the SDA line low |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The assertions check four properties on every clock. The two output-enables never switch together, and both lines are released whenever the block is idle. Done is a lone pulse that ends busy, and an error flag can only appear together with done. Other properties show only through whole bench scenarios run against a bus-level target model. These include the byte order, the repeated START on reads, the master NACK and the STOP placement after a refusal. The same goes for the exact length of each kind of transfer and the fact that later strobes and input changes do not disturb a running command.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;

    localparam int DEV_W    = 7;
    localparam int BYTE_W   = 8;
    localparam int BIT_CW   = $clog2(BYTE_W + 1);
    localparam logic [BIT_CW-1:0] ACK_SLOT = BIT_CW'(BYTE_W);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_SHIFT,
        PH_STOP
    } phase_e;

    // which byte of the compound sequence is on the wire
    typedef enum logic [2:0] {
        BY_ADDR_W,
        BY_REG,
        BY_DATA,
        BY_ADDR_R,
        BY_READ
    } byte_e;

    typedef struct packed {
        logic              rd;
        logic [DEV_W-1:0]  dev;
        logic [BYTE_W-1:0] regad;
        logic [BYTE_W-1:0] wdata;
    } cmd_t;

    function automatic logic [BYTE_W-1:0] load_byte(byte_e which, cmd_t c);
        case (which)
            BY_ADDR_W: load_byte = {c.dev, 1'b0};
            BY_REG:    load_byte = c.regad;
            BY_DATA:   load_byte = c.wdata;
            BY_ADDR_R: load_byte = {c.dev, 1'b1};
            default:   load_byte = '1;
        endcase
    endfunction

endpackage

// File: rtl/i2creg_tick.sv
module i2creg_tick #(
    parameter int QTR_CLKS = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = !restart && (cnt == LAST);
endmodule

// File: rtl/i2creg_sync.sv
module i2creg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) ff <= '1;
                else     ff <= {ff[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = ff[STAGES-1];
endmodule

// File: rtl/i2creg_seq.sv
module i2creg_seq
    import i2creg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  cmd_t              cmd_in,
    input  logic              sda_smp,
    output logic              accept,
    output logic [BYTE_W-1:0] rdata,
    output logic              busy,
    output logic              done,
    output logic              nack,
    output logic              scl_oe,
    output logic              sda_oe
);
    phase_e            phase;
    byte_e             which, follow;
    cmd_t              cmd;
    logic [1:0]        q;
    logic [BIT_CW-1:0] bitn;
    logic [BYTE_W-1:0] shreg;
    logic              got_nack;
    logic              last;

    assign accept = start && (phase == PH_IDLE);

    always_comb begin
        case (which)
            BY_ADDR_W: follow = BY_REG;
            BY_REG:    follow = cmd.rd ? BY_ADDR_R : BY_DATA;
            default:   follow = BY_READ;
        endcase
        last = (which == BY_DATA) || (which == BY_READ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            which    <= BY_ADDR_W;
            cmd      <= '0;
            q        <= '0;
            bitn     <= '0;
            shreg    <= '0;
            got_nack <= 1'b0;
            rdata    <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            nack     <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                cmd      <= cmd_in;
                phase    <= PH_START;
                which    <= BY_ADDR_W;
                q        <= '0;
                busy     <= 1'b1;
                nack     <= 1'b0;
                got_nack <= 1'b0;
                scl_oe   <= 1'b1;
            end else if (tick && phase != PH_IDLE) begin
                q <= q + 2'd1;
                case (q)
                    2'd0: begin // middle of SCL low: place SDA
                        case (phase)
                            PH_START: sda_oe <= 1'b0;
                            PH_STOP:  sda_oe <= 1'b1;
                            default:  sda_oe <= (bitn != ACK_SLOT && which != BY_READ)
                                                ? ~shreg[BYTE_W-1] : 1'b0;
                        endcase
                    end
                    2'd1: scl_oe <= 1'b0;
                    2'd2: begin // middle of SCL high: sample or make a condition
                        case (phase)
                            PH_START: sda_oe <= 1'b1;
                            PH_STOP:  sda_oe <= 1'b0;
                            default: begin
                                if (bitn != ACK_SLOT)
                                    shreg <= {shreg[BYTE_W-2:0], sda_smp};
                                else if (which != BY_READ)
                                    got_nack <= sda_smp;
                            end
                        endcase
                    end
                    default: begin // end of the bit cell
                        scl_oe <= 1'b1;
                        case (phase)
                            PH_START: begin
                                phase <= PH_SHIFT;
                                bitn  <= '0;
                                shreg <= load_byte(which, cmd);
                            end
                            PH_STOP: begin
                                phase  <= PH_IDLE;
                                scl_oe <= 1'b0;
                                busy   <= 1'b0;
                                done   <= 1'b1;
                                nack   <= got_nack;
                            end
                            default: begin
                                if (bitn != ACK_SLOT) begin
                                    bitn <= bitn + 1'b1;
                                end else begin
                                    bitn <= '0;
                                    if (got_nack || last) begin
                                        phase <= PH_STOP;
                                        if (which == BY_READ && !got_nack)
                                            rdata <= shreg;
                                    end else begin
                                        which <= follow;
                                        if (which == BY_REG && cmd.rd)
                                            phase <= PH_START;
                                        else
                                            shreg <= load_byte(follow, cmd);
                                    end
                                end
                            end
                        endcase
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2creg_master.sv
module i2creg_master
    import i2creg_pkg::*;
#(
    parameter int QTR_CLKS    = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [BYTE_W-1:0] cmd_reg,
    input  logic [BYTE_W-1:0] cmd_wdata,
    output logic [BYTE_W-1:0] rsp_rdata,
    output logic              rsp_busy,
    output logic              rsp_done,
    output logic              rsp_nack,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    logic tick, accept, sda_smp;
    cmd_t cmd_in;

    assign cmd_in = '{rd: cmd_read, dev: cmd_dev, regad: cmd_reg, wdata: cmd_wdata};

    i2creg_tick #(.QTR_CLKS(QTR_CLKS)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .tick    (tick)
    );

    i2creg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sda_in),
        .dout (sda_smp)
    );

    i2creg_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (cmd_start),
        .cmd_in  (cmd_in),
        .sda_smp (sda_smp),
        .accept  (accept),
        .rdata   (rsp_rdata),
        .busy    (rsp_busy),
        .done    (rsp_done),
        .nack    (rsp_nack),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );
endmodule

// File: rtl/i2creg_master_chk.sv
module i2creg_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_start,
    input logic rsp_busy,
    input logic rsp_done,
    input logic rsp_nack,
    input logic scl_oe,
    input logic sda_oe
);
    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (rst)
        !rsp_busy |-> (!scl_oe && !sda_oe)); // R1

    AST_NO_JOINT_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(scl_oe) |-> $stable(sda_oe)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R12

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!rsp_busy && $past(rsp_busy))); // R12

    AST_NACK_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_nack) |-> rsp_done); // R8

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (rsp_busy && cmd_start) |=> (rsp_busy || rsp_done)); // R11
endmodule

bind i2creg_master i2creg_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .rsp_busy  (rsp_busy),
    .rsp_done  (rsp_done),
    .rsp_nack  (rsp_nack),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe)
);

// File: tb/test_i2creg_master.sv
module test_i2creg_master;
    localparam int QTR = 4;
    localparam int CELL = 4 * QTR;
    localparam logic [6:0] SLV = 7'h68;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 1'b0, cmd_read = 1'b0;
    logic [6:0] cmd_dev = '0;
    logic [7:0] cmd_reg = '0, cmd_wdata = '0;
    logic [7:0] rsp_rdata;
    logic rsp_busy, rsp_done, rsp_nack, scl_oe, sda_oe;

    logic s_pull = 1'b0;
    wire  scl_line = ~scl_oe;
    wire  sda_line = ~(sda_oe | s_pull);

    always #2 clk = ~clk;

    i2creg_master #(.QTR_CLKS(QTR)) i_i2creg_master (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rsp_rdata(rsp_rdata), .rsp_busy(rsp_busy), .rsp_done(rsp_done),
        .rsp_nack(rsp_nack), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- bus-level target model ----------------
    logic [7:0] s_mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] s_sh = '0, s_ptr = '0, s_addr0 = '0, s_addr1 = '0;
    int   s_bit = 0, s_byte = 0, n_start = 0, n_stop = 0, nack_at = -1;
    bit   s_act = 0, s_sel = 0, s_rd = 0, s_rise = 0, s_mack = 0, ack;
    logic p_scl = 1'b1, p_sda = 1'b1;

    always @(scl_line, sda_line) begin
        if (p_scl === 1'b1 && scl_line === 1'b1 && p_sda === 1'b1 && sda_line === 1'b0) begin
            n_start++; s_act = 1; s_bit = 0; s_byte = 0; s_rd = 0; s_sel = 0; s_rise = 0; s_pull = 0;
        end else if (p_scl === 1'b1 && scl_line === 1'b1 && p_sda === 1'b0 && sda_line === 1'b1) begin
            if (s_act) n_stop++;
            s_act = 0; s_pull = 0;
        end else if (s_act && p_scl === 1'b0 && scl_line === 1'b1) begin
            s_rise = 1;
            if (!(s_sel && s_rd && s_byte == 1) && s_bit < 8) s_sh = {s_sh[6:0], sda_line};
            if (s_sel && s_rd && s_byte == 1 && s_bit == 8) s_mack = sda_line;
        end else if (s_act && s_rise && p_scl === 1'b1 && scl_line === 1'b0) begin
            s_rise = 0;
            s_bit++;
            if (s_bit == 8) begin
                if (s_sel && s_rd && s_byte == 1) begin
                    s_pull = 0;
                end else begin
                    ack = 0;
                    if (s_byte == 0) begin
                        if (s_sh[0]) s_addr1 = s_sh; else s_addr0 = s_sh;
                        ack = (s_sh[7:1] == SLV) && nack_at != 0;
                        s_sel = ack; s_rd = s_sh[0];
                    end else if (s_sel && !s_rd && s_byte == 1) begin
                        s_ptr = s_sh; ack = nack_at != 1;
                    end else if (s_sel && !s_rd && s_byte == 2) begin
                        ack = nack_at != 2;
                        if (ack) s_mem[s_ptr] = s_sh;
                    end
                    s_pull = ack;
                end
            end else if (s_bit == 9) begin
                s_bit = 0; s_byte++; s_pull = 0;
                if (s_sel && s_rd && s_byte == 1) s_pull = ~s_mem[s_ptr][7];
            end else if (s_sel && s_rd && s_byte == 1) begin
                s_pull = ~s_mem[s_ptr][7 - s_bit];
            end
        end
        p_scl = scl_line; p_sda = sda_line;
    end

    // ---------------- one command ----------------
    logic [7:0] exp_rdata = '0;

    task automatic run(input bit rd, input logic [6:0] dev, input logic [7:0] ra,
                       input logic [7:0] wd, input int nk, input bit stray);
        int n, cells, st0, sp0, exp_st;
        bit seen, dev_ok, enack;
        nack_at = nk; s_addr0 = '0; s_addr1 = '0; s_mack = 0;
        st0 = n_start; sp0 = n_stop;
        cmd_read = rd; cmd_dev = dev; cmd_reg = ra; cmd_wdata = wd; cmd_start = 1'b1;
        @(posedge clk); #1;
        cmd_start = 1'b0;
        // R11: inputs move after acceptance and must not matter
        cmd_read = ~rd; cmd_dev = 7'($urandom); cmd_reg = 8'($urandom); cmd_wdata = 8'($urandom);
        n = 0; seen = 0;
        while (!seen && n < 5000) begin
            @(posedge clk); #1;
            n++;
            if (n == 4) chk(rsp_busy == 1'b1, "R12 busy during transfer", rsp_busy, 1);
            if (stray && n == 50) cmd_start = 1'b1;
            if (stray && n == 51) cmd_start = 1'b0;
            if (rsp_done) seen = 1;
        end
        dev_ok = (dev == SLV);
        if (!dev_ok || nk == 0)  begin cells = 11; enack = 1; end
        else if (nk == 1)        begin cells = 20; enack = 1; end
        else if (!rd)            begin cells = 29; enack = (nk == 2); end
        else                     begin cells = 39; enack = 0; end
        exp_st = (rd && cells == 39) ? 2 : 1;
        chk(seen, "R12 done seen", seen, 1);
        chk(n == cells * CELL, "R4 R5 R6 R8 transfer length", n, cells * CELL);
        chk(rsp_nack == enack, "R8 error flag with done", rsp_nack, enack);
        chk(!rsp_busy, "R12 busy cleared at done", rsp_busy, 0);
        chk(s_addr0 == {dev, 1'b0}, "R3 first address byte", s_addr0, {dev, 1'b0});
        chk(n_start - st0 == exp_st, "R2 R6 START count", n_start - st0, exp_st);
        chk(n_stop - sp0 == 1, "R2 STOP count", n_stop - sp0, 1);
        if (!rd && !enack) exp_mem[ra] = wd;
        if (!rd) chk(s_mem[ra] == exp_mem[ra], "R5 target register", s_mem[ra], exp_mem[ra]);
        if (rd && cells == 39) begin
            exp_rdata = exp_mem[ra];
            chk(s_addr1 == {dev, 1'b1}, "R3 read address byte", s_addr1, {dev, 1'b1});
            chk(s_mack == 1'b1, "R7 master NACK on read byte", s_mack, 1);
        end
        chk(rsp_rdata == exp_rdata, "R6 R13 result byte", rsp_rdata, exp_rdata);
        @(posedge clk); #1;
        chk(!rsp_done, "R12 done one cycle", rsp_done, 0);
        chk(rsp_nack == enack, "R9 error flag held", rsp_nack, enack);
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        int seed, k, nk;
        bit rd;
        logic [6:0] dv;
        logic [7:0] ra;
        seed = $urandom(32'h5EED1);
        for (int i = 0; i < 256; i++) begin
            s_mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk(!scl_oe && !sda_oe, "R1 reset enables", {scl_oe, sda_oe}, 0);
        chk(scl_line === 1'b1 && sda_line === 1'b1, "R1 lines high", {scl_line, sda_line}, 3);
        chk(!rsp_busy && !rsp_done && !rsp_nack, "R1 reset flags", {rsp_busy, rsp_done, rsp_nack}, 0);
        chk(rsp_rdata == 8'h00, "R1 reset result", rsp_rdata, 0);

        run(0, SLV, 8'h05, 8'h3C, -1, 0);         // R5 plain write
        run(1, SLV, 8'h05, 8'h00, -1, 0);         // R6 read back
        run(0, SLV, 8'hFF, 8'h00, -1, 1);         // R11 stray strobe during write
        run(1, SLV, 8'hFF, 8'h00, -1, 1);         // R11 stray strobe during read
        run(0, SLV, 8'h80, 8'hFF, -1, 0);
        run(1, SLV, 8'h80, 8'h00, -1, 0);
        run(0, SLV ^ 7'h01, 8'h07, 8'hAA, -1, 0); // R8 unknown device
        run(1, SLV ^ 7'h40, 8'h07, 8'h00, -1, 0); // R8 R13 unknown device on read
        run(0, SLV, 8'h07, 8'h55, 1, 0);          // R8 index refused
        run(0, SLV, 8'h07, 8'h66, 2, 0);          // R8 value refused
        run(1, SLV, 8'h07, 8'h00, 1, 0);          // R8 index refused on read
        run(0, SLV, 8'h07, 8'h77, 0, 0);          // R8 address refused
        run(1, SLV, 8'h07, 8'h00, -1, 0);         // R9 flag cleared, unchanged register

        for (int t = 0; t < 40; t++) begin
            rd = 1'($urandom);
            ra = ($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 16);
            dv = ($urandom % 8 == 0) ? (SLV ^ 7'(1 + $urandom % 127)) : SLV;
            k  = $urandom % 10;
            nk = (k < 3) ? k : -1;
            run(rd, dv, ra, 8'($urandom), nk, t % 7 == 3);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule